// File: doc/BRIEF.md
# Two-Phase Randomized Routing Header Unit

This block sits on a flit stream at a network endpoint and makes packets take a random detour. In insert mode it places one extra flit in front of each packet. That flit carries a pseudo-random node number, so switches first route the packet to that intermediate node. In remove mode, used at the intermediate node, it drops the first flit of each packet. The real destination header behind it then becomes the leading flit, and the packet is routed on to its final node. In pass-through mode it forwards flits unchanged.

The random node number comes from a 16-bit maximal-length linear feedback shift register. The register advances once per packet. Its state is scaled into the range 0 to NODE_CNT-1. A seed port reloads the register, and a zero seed is replaced so the register never locks up.

All outputs are registered. The stream interfaces use valid/ready handshakes and a last-flit marker. The block makes no routing decision itself.

Top module: `detour_hdr_unit`

## Requirements
- R1: Mode 2'b00 (pass) and mode 2'b11 forward every flit unchanged: same data, same last bit, same order, nothing added or removed.
- R2: Mode 2'b01 (insert) emits one extra flit before each packet. This flit has last=0 and data equal to the zero-extended value (L*NODE_CNT)>>16, where L is the register state at that moment. The packet's own flits follow unchanged.
- R3: The register uses the polynomial x^16+x^14+x^13+x^11+1. Each step computes next = {L[14:0], L[15]^L[13]^L[12]^L[10]}. It resets to 16'hACE1. It steps exactly once per packet, when the packet's first flit is accepted, in every mode.
- R4: A seed_load pulse sets the register to seed_value in the next cycle, and a zero seed_value loads 16'hACE1 instead. A load takes priority over a step, and the register is never zero.
- R5: Mode 2'b10 (remove) discards the first flit of each packet and forwards the remaining flits unchanged.
- R6: A one-flit packet in remove mode produces no output flit. It raises short_pkt_err for exactly the cycle after that flit is accepted.
- R7: The mode is taken from the mode input at the start of each packet, when the extra flit is emitted or the first flit is accepted. Changes to the mode input during the rest of the packet have no effect.
- R8: While out_valid is high and out_ready is low, out_data and out_last hold. No flit is lost or duplicated under any out_ready pattern.
- R9: After reset, out_valid and short_pkt_err are low and in_ready is high.
- R10: in_ready is high only when the output register is empty or being emptied in the same cycle. It is low for the one cycle in which the extra flit is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 pass, 01 insert header, 10 remove header, 11 pass |
| seed_load | input | 1 | Load seed_value into the random register |
| seed_value | input | LFSR_W | Seed; zero is replaced by 16'hACE1 |
| in_data | input | DATA_W | Input flit data |
| in_valid | input | 1 | Input flit valid |
| in_last | input | 1 | Input flit is the last of its packet |
| in_ready | output | 1 | Block accepts the input flit this cycle |
| out_data | output | DATA_W | Output flit data |
| out_valid | output | 1 | Output flit valid |
| out_last | output | 1 | Output flit is the last of its packet |
| out_ready | input | 1 | Downstream accepts the output flit |
| short_pkt_err | output | 1 | One-cycle pulse: single-flit packet in remove mode |

## Verification
The bench sends packets of several lengths in all three modes. The one-flit case separates insertion, where a header and the flit both come out, from removal, where nothing comes out and an error pulse appears.

Insert-mode packets placed after pass and remove packets show that the register steps once per packet regardless of mode. Loading a seed of zero and then a non-zero seed shows both the fallback value and the load itself.

Changing the mode input in the middle of each packet tells a packet-latched mode from a live one. Random backpressure on out_ready separates correct holding from lost or repeated flits.

// File: rtl/detour_pkg.sv
package detour_pkg;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_PREP  = 2'b01,
        MODE_STRIP = 2'b10,
        MODE_ALT   = 2'b11
    } mode_e;

    localparam int unsigned LFSR_BITS     = 16;
    localparam logic [15:0] LFSR_TAPS     = 16'hB400;
    localparam logic [15:0] LFSR_FALLBACK = 16'hACE1;

endpackage

// File: rtl/detour_lfsr.sv
module detour_lfsr #(
    parameter int unsigned W        = 16,
    parameter logic [W-1:0] TAPS     = 16'hB400,
    parameter logic [W-1:0] FALLBACK = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] state
);

    logic [W-1:0] state_d;
    logic [W-1:0] state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = (load_val == '0) ? FALLBACK : load_val;
        end else if (step) begin
            state_d = {state_q[W-2:0], ^(state_q & TAPS)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FALLBACK;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/detour_pick.sv
module detour_pick #(
    parameter int unsigned W     = 16,
    parameter int unsigned NODES = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic [W-1:0]     state,
    output logic [IDX_W-1:0] idx
);

    localparam int unsigned NW = $clog2(NODES + 1);
    localparam int unsigned PW = W + NW;

    logic [PW-1:0] prod;

    always_comb begin
        prod = PW'(state) * PW'(NODES);
        idx  = prod[W +: IDX_W];
    end

endmodule

// File: rtl/detour_hdr_unit.sv
module detour_hdr_unit
    import detour_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NODE_CNT = 64,
    parameter int unsigned LFSR_W   = LFSR_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              seed_load,
    input  logic [LFSR_W-1:0] seed_value,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready,
    output logic              short_pkt_err
);

    localparam int unsigned IDX_W = (NODE_CNT > 1) ? $clog2(NODE_CNT) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] odata;
        logic              olast;
        logic              ovld;
        logic              sop;
        logic              hdr_done;
        mode_e             pmode;
        logic              err;
    } st_t;

    st_t st_d, st_q;

    logic [LFSR_W-1:0] lfsr_state;
    logic [IDX_W-1:0]  hdr_idx;
    logic              adv, at_head, ins_hdr, acc, first_acc, drop;
    mode_e             cur_mode;

    detour_lfsr #(
        .W       (LFSR_W),
        .TAPS    (LFSR_W'(LFSR_TAPS)),
        .FALLBACK(LFSR_W'(LFSR_FALLBACK))
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seed_load),
        .load_val(seed_value),
        .step    (first_acc),
        .state   (lfsr_state)
    );

    detour_pick #(
        .W    (LFSR_W),
        .NODES(NODE_CNT),
        .IDX_W(IDX_W)
    ) u_pick (
        .state(lfsr_state),
        .idx  (hdr_idx)
    );

    always_comb begin
        adv       = !st_q.ovld || out_ready;
        at_head   = st_q.sop && !st_q.hdr_done;
        cur_mode  = at_head ? mode_e'(mode) : st_q.pmode;
        ins_hdr   = at_head && (cur_mode == MODE_PREP);
        in_ready  = adv && !ins_hdr;
        acc       = in_valid && in_ready;
        first_acc = acc && st_q.sop;
        drop      = first_acc && (cur_mode == MODE_STRIP);

        st_d     = st_q;
        st_d.err = 1'b0;
        if (adv) begin
            st_d.ovld = 1'b0;
        end
        if (ins_hdr && in_valid && adv) begin
            st_d.odata    = DATA_W'(hdr_idx);
            st_d.olast    = 1'b0;
            st_d.ovld     = 1'b1;
            st_d.hdr_done = 1'b1;
            st_d.pmode    = MODE_PREP;
        end
        if (acc) begin
            if (st_q.sop) begin
                st_d.pmode = cur_mode;
            end
            if (drop) begin
                st_d.err = in_last;
            end else begin
                st_d.odata = in_data;
                st_d.olast = in_last;
                st_d.ovld  = 1'b1;
            end
            st_d.sop = in_last;
            if (in_last) begin
                st_d.hdr_done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.odata    <= '0;
            st_q.olast    <= 1'b0;
            st_q.ovld     <= 1'b0;
            st_q.sop      <= 1'b1;
            st_q.hdr_done <= 1'b0;
            st_q.pmode    <= MODE_PASS;
            st_q.err      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data      = st_q.odata;
    assign out_last      = st_q.olast;
    assign out_valid     = st_q.ovld;
    assign short_pkt_err = st_q.err;

endmodule

// File: rtl/detour_hdr_chk.sv
module detour_hdr_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LFSR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seed_load,
    input logic [LFSR_W-1:0] seed_value,
    input logic              in_valid,
    input logic              in_last,
    input logic              in_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_last,
    input logic              out_ready,
    input logic              short_pkt_err,
    input logic [LFSR_W-1:0] lfsr_state
);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R10
    ready_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid || out_ready));

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_pkt_err |-> $past(in_valid && in_ready && in_last));

    // R4
    seed_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_value != '0) |=> (lfsr_state == $past(seed_value)));

    // R4
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);

endmodule

bind detour_hdr_unit detour_hdr_chk #(
    .DATA_W(DATA_W),
    .LFSR_W(LFSR_W)
) u_hdr_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .seed_load    (seed_load),
    .seed_value   (seed_value),
    .in_valid     (in_valid),
    .in_last      (in_last),
    .in_ready     (in_ready),
    .out_data     (out_data),
    .out_valid    (out_valid),
    .out_last     (out_last),
    .out_ready    (out_ready),
    .short_pkt_err(short_pkt_err),
    .lfsr_state   (lfsr_state)
);

// File: tb/test_detour_hdr_unit.sv
`timescale 1ns/1ps
module test_detour_hdr_unit;

    localparam int unsigned DW = 16;
    localparam int unsigned NN = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          seed_load = 1'b0;
    logic [15:0]   seed_value = '0;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic          out_last;
    logic          out_ready = 1'b1;
    logic          short_pkt_err;

    detour_hdr_unit #(.DATA_W(DW), .NODE_CNT(NN), .LFSR_W(16)) i_detour_hdr_unit (
        .clk(clk), .rst_n(rst_n), .mode(mode), .seed_load(seed_load),
        .seed_value(seed_value), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
        .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
        .short_pkt_err(short_pkt_err)
    );

    always #10 clk = ~clk;

    int          n_chk = 0;
    int          n_fail = 0;
    int          err_seen = 0;
    int          err_exp = 0;
    logic        stall_en = 1'b0;
    logic        done = 1'b0;
    logic [15:0] m_lfsr = 16'hACE1;
    logic [DW:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            out_ready = stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
            if (short_pkt_err) err_seen++;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected flit", {15'b0, out_last, out_data}, 32'h0);
                end else begin
                    logic [DW:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({out_last, out_data} == e, t, {15'b0, out_last, out_data}, {15'b0, e});
                end
            end
        end
    end

    task automatic load_seed(input logic [15:0] v);
        @(negedge clk);
        in_valid = 1'b0;
        seed_load = 1'b1;
        seed_value = v;
        @(negedge clk);
        seed_load = 1'b0;
        m_lfsr = (v == 16'h0) ? 16'hACE1 : v;
    endtask

    task automatic send_pkt(input logic [1:0] md, input int len, input logic [DW-1:0] base, input string tag);
        logic [31:0] hdr;
        hdr = (32'(m_lfsr) * NN) >> 16;
        if (md == 2'b01) begin
            exp_q.push_back({1'b0, DW'(hdr)});
            tag_q.push_back({tag, " R2 R3 header"});
        end
        for (int i = 0; i < len; i++) begin
            if (!(md == 2'b10 && i == 0)) begin
                exp_q.push_back({(i == len - 1), DW'(base + DW'(i))});
                tag_q.push_back({tag, " R7 R8 body"});
            end
        end
        m_lfsr = m_step(m_lfsr);
        for (int i = 0; i < len; i++) begin
            logic take;
            take = 1'b0;
            while (!take) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_data = base + DW'(i);
                in_last = (i == len - 1);
                mode = (i == 0) ? md : ~md;
                #1;
                take = in_ready;
                @(posedge clk);
            end
        end
        if (md == 2'b10 && len == 1) begin
            err_exp++;
            @(negedge clk);
            in_valid = 1'b0;
            check(short_pkt_err == 1'b1, "R6 error pulse", {31'b0, short_pkt_err}, 32'h1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check(out_valid == 1'b0, "R9 out_valid", {31'b0, out_valid}, 32'h0);
        check(short_pkt_err == 1'b0, "R9 err", {31'b0, short_pkt_err}, 32'h0);
        check(in_ready == 1'b1, "R9 in_ready", {31'b0, in_ready}, 32'h1);

        send_pkt(2'b00, 3, 16'h1000, "R1 pass");
        send_pkt(2'b00, 1, 16'h1100, "R1 pass single");
        send_pkt(2'b11, 2, 16'h1200, "R1 mode3");
        send_pkt(2'b01, 4, 16'h2000, "R2 insert");
        send_pkt(2'b01, 1, 16'h2100, "R2 insert single");
        send_pkt(2'b10, 3, 16'h3000, "R5 remove");
        send_pkt(2'b10, 2, 16'h3100, "R5 remove two");
        send_pkt(2'b10, 1, 16'h3200, "R6 remove single");
        send_pkt(2'b01, 2, 16'h2200, "R3 step after remove");

        load_seed(16'h0000);
        send_pkt(2'b01, 2, 16'h4000, "R4 zero seed");
        load_seed(16'h1234);
        send_pkt(2'b01, 2, 16'h4100, "R4 seed");
        load_seed(16'hFFFF);
        send_pkt(2'b01, 1, 16'h4200, "R4 seed ones");

        stall_en = 1'b1;
        for (int k = 0; k < 40; k++) begin
            send_pkt(2'(k % 4), 1 + (k % 5), DW'(16'h5000 + k * 16), "R8 stall mix");
        end
        @(negedge clk);
        in_valid = 1'b0;
        stall_en = 1'b0;
        for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8 all flits delivered", exp_q.size(), 32'h0);
        check(err_seen == err_exp, "R6 error count", err_seen, err_exp);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule